// File: doc/BRIEF.md
# Dual-Clock Inter-Processor Mailbox

This block connects two processors that sit on separate buses, each running from its own clock. Each processor sees a register bank of its own. Through that bank it can send 32-bit words to the other processor on four independent data channels. It can ring four data-less doorbells. It receives the other side's words and doorbells in the same bank. Both ports are built from the same per-side logic, and the two banks mirror each other. Each flag that changes in one clock domain reaches the other domain as a toggle, and the toggle passes through a multi-flop synchronizer before it is used there.

A data channel behaves as a one-word slot. The writer's transmit-empty flag drops when it writes the word. The reader's receive-full flag rises once the word has crossed. When the reader takes the word, an acknowledge toggle travels back and re-arms the writer. A doorbell raises a pending bit on the far side. The far side clears that bit by writing a one to it, and the ringer sees its doorbell as busy until the clear has returned. One port is the A-facing side, selected by a single input. Only that side may raise the reset-request line toward the other processor. Each port drives one level interrupt, formed from its enabled flags.

Word offsets on each port: 0 to 3 transmit registers, 4 to 7 receive registers, 8 status, 9 control, 10 doorbell ring.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset each port reads status (offset 8) as 0x0000000F: all four transmit-empty bits [3:0] are set, and receive-full [7:4], doorbell pending [11:8], doorbell busy [15:12], the error bit 16 and the peer-reset bit 17 are clear. Control (offset 9) reads 0, and the interrupt and peer-reset outputs are low.
- R2: A write to transmit register c (offset c) with transmit-empty bit c set clears that bit on the next cycle. Some synchronizer cycles later, the other port shows receive-full bit 4+c set, and its receive register at offset 4+c returns the written word.
- R3: A read of receive register 4+c while receive-full bit 4+c is set clears that bit on the next cycle. After the acknowledge crosses back, the sending port's transmit-empty bit c sets again.
- R4: A write to transmit register c while its transmit-empty bit is clear is ignored, so the far side still receives the earlier word. It also sets the sticky error bit 16, which stays set until a write to status with bit 16 set clears it.
- R5: Writing a one to bit d of the ring register (offset 10) on a port sets that port's busy bit 12+d. The other port's pending bit 8+d then sets. Writing a one to pending bit 8+d on the receiver clears it, and once that clear has returned the sender's busy bit clears.
- R6: A ring write to a doorbell whose busy bit is set is ignored: after the pending bit is cleared, it does not come back.
- R7: Each port's interrupt output is high exactly when an enabled flag is set. Control bits [3:0] enable transmit-empty, bits [7:4] enable receive-full and bits [11:8] enable doorbell pending, each bit for the matching channel.
- R8: The side-select input (sideSel) picks the A-facing port: port 0 when it is 0, port 1 when it is 1. Control bit 12 written on the A-facing port drives the other port's peer-reset output high and its status bit 17 high, after synchronization. The same write on the other port is ignored, and bit 12 reads back as 0 there.
- R9: Channels are independent: sending on channel c sets only receive-full bit 4+c on the far side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sideSel | input | 1 | Chooses which port is the A-facing side |
| p0Clk | input | 1 | Port 0 bus clock |
| p0RstN | input | 1 | Port 0 asynchronous reset, active low |
| p0WrEn | input | 1 | Port 0 write strobe |
| p0RdEn | input | 1 | Port 0 read strobe (reads have side effects on receive registers) |
| p0Addr | input | 4 | Port 0 word offset |
| p0WrData | input | 32 | Port 0 write data |
| p0RdData | output | 32 | Port 0 read data, valid in the cycle of the access |
| p0Irq | output | 1 | Port 0 level interrupt |
| p0PeerRst | output | 1 | Reset request from the A-facing side, seen on port 0 |
| p1Clk | input | 1 | Port 1 bus clock |
| p1RstN | input | 1 | Port 1 asynchronous reset, active low |
| p1WrEn | input | 1 | Port 1 write strobe |
| p1RdEn | input | 1 | Port 1 read strobe |
| p1Addr | input | 4 | Port 1 word offset |
| p1WrData | input | 32 | Port 1 write data |
| p1RdData | output | 32 | Port 1 read data |
| p1Irq | output | 1 | Port 1 level interrupt |
| p1PeerRst | output | 1 | Reset request from the A-facing side, seen on port 1 |

## Verification
The bench uses the default build: 32-bit words, four data channels, four doorbells and two synchronizer stages. The two clocks run at 4 ns and 7 ns, so their edges drift against each other. At this size the bench can sweep every data channel and every doorbell in both directions. It also runs the reset-request path under both values of the side-select input. Each word the bench sends is an arithmetic function of its channel and direction, so a crossed or stale channel shows up as a wrong value.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  localparam int MBX_CH = 4;
  localparam int MBX_DB = 4;

  localparam int MBX_TX_BASE = 0;
  localparam int MBX_RX_BASE = MBX_CH;
  localparam int MBX_STAT    = 2 * MBX_CH;
  localparam int MBX_CTRL    = MBX_STAT + 1;
  localparam int MBX_RING    = MBX_STAT + 2;
  localparam int MBX_ADDR_W  = $clog2(MBX_RING + 1);

  // status layout
  localparam int ST_RXF  = MBX_CH;
  localparam int ST_PEND = 2 * MBX_CH;
  localparam int ST_BUSY = 2 * MBX_CH + MBX_DB;
  localparam int ST_ERR  = 2 * MBX_CH + 2 * MBX_DB;
  localparam int ST_PRST = ST_ERR + 1;
  localparam int ST_W    = ST_PRST + 1;

  // control layout
  localparam int CT_IERX = MBX_CH;
  localparam int CT_IEDB = 2 * MBX_CH;
  localparam int CT_RST  = 2 * MBX_CH + MBX_DB;
  localparam int CT_W    = CT_RST + 1;

  typedef struct packed {
    logic [MBX_CH-1:0] wrTx;
    logic [MBX_CH-1:0] rdRx;
    logic              wrStat;
    logic              wrCtrl;
    logic              wrRing;
  } mbx_strb_t;
endpackage

// File: rtl/mbx_sync.sv
`timescale 1ns/1ps
module mbx_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/mbx_ctrl.sv
`timescale 1ns/1ps
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [MBX_ADDR_W-1:0] addr,
  output mbx_strb_t             strb
);
  always_comb begin
    strb = '0;
    for (int c = 0; c < MBX_CH; c++) begin
      strb.wrTx[c] = wrEn && (addr == MBX_ADDR_W'(MBX_TX_BASE + c));
      strb.rdRx[c] = rdEn && (addr == MBX_ADDR_W'(MBX_RX_BASE + c));
    end
    strb.wrStat = wrEn && (addr == MBX_ADDR_W'(MBX_STAT));
    strb.wrCtrl = wrEn && (addr == MBX_ADDR_W'(MBX_CTRL));
    strb.wrRing = wrEn && (addr == MBX_ADDR_W'(MBX_RING));
  end
endmodule

// File: rtl/mbx_datapath.sv
`timescale 1ns/1ps
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int SYNC_STG = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           isSideA,
  input  mbx_strb_t                      strb,
  input  logic [MBX_ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]              wrData,
  output logic [DATA_W-1:0]              rdData,
  output logic                           irq,
  output logic                           peerRst,
  // toward the far side
  output logic [MBX_CH-1:0][DATA_W-1:0]  txData,
  output logic [MBX_CH-1:0]              sendTgl,
  output logic [MBX_CH-1:0]              ackTgl,
  output logic [MBX_DB-1:0]              ringTgl,
  output logic [MBX_DB-1:0]              clrTgl,
  output logic                           rstReq,
  // from the far side
  input  logic [MBX_CH-1:0][DATA_W-1:0]  farTxData,
  input  logic [MBX_CH-1:0]              farSendTgl,
  input  logic [MBX_CH-1:0]              farAckTgl,
  input  logic [MBX_DB-1:0]              farRingTgl,
  input  logic [MBX_DB-1:0]              farClrTgl,
  input  logic                           farRstReq,
  // flag state
  output logic [MBX_CH-1:0]              txEmpty,
  output logic [MBX_CH-1:0]              rxFull,
  output logic [MBX_DB-1:0]              pend,
  output logic [MBX_DB-1:0]              busy,
  output logic                           err
);
  localparam int TW = 2 * MBX_CH + 2 * MBX_DB;
  localparam int SW = TW + 1;

  logic [SW-1:0] syncIn, syncOut;
  logic [TW-1:0] tglPrev, tglEdge;
  logic [MBX_CH-1:0] sendEdge, ackEdge;
  logic [MBX_DB-1:0] ringEdge, clrEdge;
  logic [MBX_CH-1:0][DATA_W-1:0] rxData;
  logic [MBX_CH-1:0] ieTx, ieRx;
  logic [MBX_DB-1:0] ieDb;
  logic txOverWr;
  logic [ST_W-1:0] statVec;
  logic [CT_W-1:0] ctrlVec;

  assign syncIn = {farRstReq, farClrTgl, farRingTgl, farAckTgl, farSendTgl};

  mbx_sync #(.WIDTH(SW), .STAGES(SYNC_STG)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (syncIn),
    .dout(syncOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tglPrev <= '0;
    else       tglPrev <= syncOut[TW-1:0];
  end

  assign tglEdge  = syncOut[TW-1:0] ^ tglPrev;
  assign sendEdge = tglEdge[MBX_CH-1:0];
  assign ackEdge  = tglEdge[MBX_CH +: MBX_CH];
  assign ringEdge = tglEdge[2*MBX_CH +: MBX_DB];
  assign clrEdge  = tglEdge[2*MBX_CH+MBX_DB +: MBX_DB];
  assign peerRst  = syncOut[TW] & ~isSideA;

  assign txOverWr = |(strb.wrTx & ~txEmpty);

  // data channels
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txData  <= '0;
      sendTgl <= '0;
      txEmpty <= '1;
      rxData  <= '0;
      rxFull  <= '0;
      ackTgl  <= '0;
    end else begin
      for (int c = 0; c < MBX_CH; c++) begin
        if (strb.wrTx[c] && txEmpty[c]) begin
          txData[c]  <= wrData;
          sendTgl[c] <= ~sendTgl[c];
          txEmpty[c] <= 1'b0;
        end else if (ackEdge[c]) begin
          txEmpty[c] <= 1'b1;
        end
        if (sendEdge[c]) begin
          rxData[c] <= farTxData[c];
          rxFull[c] <= 1'b1;
        end else if (strb.rdRx[c] && rxFull[c]) begin
          rxFull[c] <= 1'b0;
          ackTgl[c] <= ~ackTgl[c];
        end
      end
    end
  end

  // doorbells
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ringTgl <= '0;
      busy    <= '0;
      pend    <= '0;
      clrTgl  <= '0;
    end else begin
      for (int d = 0; d < MBX_DB; d++) begin
        if (strb.wrRing && wrData[d] && !busy[d]) begin
          ringTgl[d] <= ~ringTgl[d];
          busy[d]    <= 1'b1;
        end else if (clrEdge[d]) begin
          busy[d] <= 1'b0;
        end
        if (ringEdge[d]) begin
          pend[d] <= 1'b1;
        end else if (strb.wrStat && wrData[ST_PEND+d] && pend[d]) begin
          pend[d]   <= 1'b0;
          clrTgl[d] <= ~clrTgl[d];
        end
      end
    end
  end

  // control and sticky error
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ieTx   <= '0;
      ieRx   <= '0;
      ieDb   <= '0;
      rstReq <= 1'b0;
      err    <= 1'b0;
    end else begin
      if (strb.wrCtrl) begin
        ieTx   <= wrData[MBX_CH-1:0];
        ieRx   <= wrData[CT_IERX +: MBX_CH];
        ieDb   <= wrData[CT_IEDB +: MBX_DB];
        rstReq <= wrData[CT_RST] & isSideA;
      end
      err <= txOverWr | (err & ~(strb.wrStat & wrData[ST_ERR]));
    end
  end

  assign irq = |(txEmpty & ieTx) | |(rxFull & ieRx) | |(pend & ieDb);

  assign statVec = {peerRst, err, busy, pend, rxFull, txEmpty};
  assign ctrlVec = {rstReq, ieDb, ieRx, ieTx};

  always_comb begin
    rdData = '0;
    for (int c = 0; c < MBX_CH; c++) begin
      if (addr == MBX_ADDR_W'(MBX_TX_BASE + c)) rdData = txData[c];
      if (addr == MBX_ADDR_W'(MBX_RX_BASE + c)) rdData = rxData[c];
    end
    if (addr == MBX_ADDR_W'(MBX_STAT)) rdData = DATA_W'(statVec);
    if (addr == MBX_ADDR_W'(MBX_CTRL)) rdData = DATA_W'(ctrlVec);
  end
endmodule

// File: rtl/ipc_mailbox.sv
`timescale 1ns/1ps
module ipc_mailbox
  import mbx_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int SYNC_STG = 2
) (
  input  logic                  sideSel,
  input  logic                  p0Clk,
  input  logic                  p0RstN,
  input  logic                  p0WrEn,
  input  logic                  p0RdEn,
  input  logic [MBX_ADDR_W-1:0] p0Addr,
  input  logic [DATA_W-1:0]     p0WrData,
  output logic [DATA_W-1:0]     p0RdData,
  output logic                  p0Irq,
  output logic                  p0PeerRst,
  input  logic                  p1Clk,
  input  logic                  p1RstN,
  input  logic                  p1WrEn,
  input  logic                  p1RdEn,
  input  logic [MBX_ADDR_W-1:0] p1Addr,
  input  logic [DATA_W-1:0]     p1WrData,
  output logic [DATA_W-1:0]     p1RdData,
  output logic                  p1Irq,
  output logic                  p1PeerRst
);
  logic                          clkV [2];
  logic                          rstV [2];
  logic                          wrV  [2];
  logic                          rdV  [2];
  logic [MBX_ADDR_W-1:0]         addrV[2];
  logic [DATA_W-1:0]             wdV  [2];
  logic [DATA_W-1:0]             rdDataV[2];
  logic                          irqV [2];
  logic                          prV  [2];
  logic                          sideA[2];
  mbx_strb_t                     strbV[2];
  logic [MBX_CH-1:0][DATA_W-1:0] txDataV[2];
  logic [MBX_CH-1:0]             sendV[2];
  logic [MBX_CH-1:0]             ackV [2];
  logic [MBX_DB-1:0]             ringV[2];
  logic [MBX_DB-1:0]             clrV [2];
  logic                          rstReqV[2];
  logic [MBX_CH-1:0]             sTxEmpty[2];
  logic [MBX_CH-1:0]             sRxFull [2];
  logic [MBX_DB-1:0]             sPend   [2];
  logic [MBX_DB-1:0]             sBusy   [2];
  logic                          sErr    [2];

  assign clkV[0]  = p0Clk;    assign clkV[1]  = p1Clk;
  assign rstV[0]  = p0RstN;   assign rstV[1]  = p1RstN;
  assign wrV[0]   = p0WrEn;   assign wrV[1]   = p1WrEn;
  assign rdV[0]   = p0RdEn;   assign rdV[1]   = p1RdEn;
  assign addrV[0] = p0Addr;   assign addrV[1] = p1Addr;
  assign wdV[0]   = p0WrData; assign wdV[1]   = p1WrData;
  assign sideA[0] = ~sideSel; assign sideA[1] = sideSel;

  assign p0RdData  = rdDataV[0];
  assign p1RdData  = rdDataV[1];
  assign p0Irq     = irqV[0];
  assign p1Irq     = irqV[1];
  assign p0PeerRst = prV[0];
  assign p1PeerRst = prV[1];

  for (genvar s = 0; s < 2; s++) begin : g_side
    localparam int F = 1 - s;

    mbx_ctrl u_ctrl (
      .wrEn(wrV[s]),
      .rdEn(rdV[s]),
      .addr(addrV[s]),
      .strb(strbV[s])
    );

    mbx_datapath #(.DATA_W(DATA_W), .SYNC_STG(SYNC_STG)) u_dp (
      .clk       (clkV[s]),
      .rstN      (rstV[s]),
      .isSideA   (sideA[s]),
      .strb      (strbV[s]),
      .addr      (addrV[s]),
      .wrData    (wdV[s]),
      .rdData    (rdDataV[s]),
      .irq       (irqV[s]),
      .peerRst   (prV[s]),
      .txData    (txDataV[s]),
      .sendTgl   (sendV[s]),
      .ackTgl    (ackV[s]),
      .ringTgl   (ringV[s]),
      .clrTgl    (clrV[s]),
      .rstReq    (rstReqV[s]),
      .farTxData (txDataV[F]),
      .farSendTgl(sendV[F]),
      .farAckTgl (ackV[F]),
      .farRingTgl(ringV[F]),
      .farClrTgl (clrV[F]),
      .farRstReq (rstReqV[F]),
      .txEmpty   (sTxEmpty[s]),
      .rxFull    (sRxFull[s]),
      .pend      (sPend[s]),
      .busy      (sBusy[s]),
      .err       (sErr[s])
    );
  end
endmodule

// File: rtl/mbx_checker.sv
`timescale 1ns/1ps
module mbx_checker
  import mbx_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic                  rdEn,
  input logic [MBX_ADDR_W-1:0] addr,
  input logic                  errClrBit,
  input logic [MBX_DB-1:0]     ringBits,
  input logic                  irq,
  input logic [MBX_CH-1:0]     txEmpty,
  input logic [MBX_CH-1:0]     rxFull,
  input logic [MBX_DB-1:0]     pend,
  input logic [MBX_DB-1:0]     busy,
  input logic                  err
);
  for (genvar c = 0; c < MBX_CH; c++) begin : g_ch
    // R2: a write into an empty slot takes it
    a_r2_write_takes_slot: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == MBX_ADDR_W'(MBX_TX_BASE + c) && txEmpty[c]) |=> !txEmpty[c]);
    // R3: reading a full slot frees it
    a_r3_read_frees_slot: assert property (@(posedge clk) disable iff (!rstN)
      (rdEn && addr == MBX_ADDR_W'(MBX_RX_BASE + c) && rxFull[c]) |=> !rxFull[c]);
    // R4: writing an occupied slot flags an error
    a_r4_overwrite_flags: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == MBX_ADDR_W'(MBX_TX_BASE + c) && !txEmpty[c]) |=> err);
  end

  for (genvar d = 0; d < MBX_DB; d++) begin : g_db
    // R5: ringing an idle doorbell marks it busy
    a_r5_ring_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == MBX_ADDR_W'(MBX_RING) && ringBits[d] && !busy[d]) |=> busy[d]);
  end

  // R4: error bit holds until cleared
  a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (err && !(wrEn && addr == MBX_ADDR_W'(MBX_STAT) && errClrBit)) |=> err);

  // R7: no set flag, no interrupt
  a_r7_irq_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (txEmpty == '0 && rxFull == '0 && pend == '0) |-> !irq);
endmodule

bind ipc_mailbox mbx_checker u_chk0 (
  .clk      (p0Clk),
  .rstN     (p0RstN),
  .wrEn     (p0WrEn),
  .rdEn     (p0RdEn),
  .addr     (p0Addr),
  .errClrBit(p0WrData[mbx_pkg::ST_ERR]),
  .ringBits (p0WrData[mbx_pkg::MBX_DB-1:0]),
  .irq      (p0Irq),
  .txEmpty  (sTxEmpty[0]),
  .rxFull   (sRxFull[0]),
  .pend     (sPend[0]),
  .busy     (sBusy[0]),
  .err      (sErr[0])
);

bind ipc_mailbox mbx_checker u_chk1 (
  .clk      (p1Clk),
  .rstN     (p1RstN),
  .wrEn     (p1WrEn),
  .rdEn     (p1RdEn),
  .addr     (p1Addr),
  .errClrBit(p1WrData[mbx_pkg::ST_ERR]),
  .ringBits (p1WrData[mbx_pkg::MBX_DB-1:0]),
  .irq      (p1Irq),
  .txEmpty  (sTxEmpty[1]),
  .rxFull   (sRxFull[1]),
  .pend     (sPend[1]),
  .busy     (sBusy[1]),
  .err      (sErr[1])
);

// File: tb/ipc_mailbox_tb_top.sv
`timescale 1ns/1ps
module ipc_mailbox_tb_top;
  import mbx_pkg::*;

  logic        sideSel;
  logic        p0Clk = 1'b0, p1Clk = 1'b0;
  logic        p0RstN, p1RstN;
  logic        p0WrEn, p0RdEn, p1WrEn, p1RdEn;
  logic [3:0]  p0Addr, p1Addr;
  logic [31:0] p0WrData, p1WrData, p0RdData, p1RdData;
  logic        p0Irq, p1Irq, p0PeerRst, p1PeerRst;
  logic [31:0] d;
  logic [31:0] w;
  int checks = 0;
  int errors = 0;

  always #2   p0Clk = ~p0Clk;   // 250 MHz
  always #3.5 p1Clk = ~p1Clk;

  ipc_mailbox dut_i (
    .sideSel(sideSel),
    .p0Clk(p0Clk), .p0RstN(p0RstN), .p0WrEn(p0WrEn), .p0RdEn(p0RdEn),
    .p0Addr(p0Addr), .p0WrData(p0WrData), .p0RdData(p0RdData),
    .p0Irq(p0Irq), .p0PeerRst(p0PeerRst),
    .p1Clk(p1Clk), .p1RstN(p1RstN), .p1WrEn(p1WrEn), .p1RdEn(p1RdEn),
    .p1Addr(p1Addr), .p1WrData(p1WrData), .p1RdData(p1RdData),
    .p1Irq(p1Irq), .p1PeerRst(p1PeerRst)
  );

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWr(input int p, input int a, input logic [31:0] v);
    if (p == 0) begin
      @(negedge p0Clk); p0Addr = 4'(a); p0WrData = v; p0WrEn = 1'b1;
      @(negedge p0Clk); p0WrEn = 1'b0;
    end else begin
      @(negedge p1Clk); p1Addr = 4'(a); p1WrData = v; p1WrEn = 1'b1;
      @(negedge p1Clk); p1WrEn = 1'b0;
    end
  endtask

  task automatic busRd(input int p, input int a, output logic [31:0] v);
    if (p == 0) begin
      @(negedge p0Clk); p0Addr = 4'(a); p0RdEn = 1'b1;
      #0.5 v = p0RdData;
      @(negedge p0Clk); p0RdEn = 1'b0;
    end else begin
      @(negedge p1Clk); p1Addr = 4'(a); p1RdEn = 1'b1;
      #0.5 v = p1RdData;
      @(negedge p1Clk); p1RdEn = 1'b0;
    end
  endtask

  task automatic waitStat(input int p, input logic [31:0] mask, input logic [31:0] val,
                          output logic [31:0] v);
    for (int i = 0; i < 100; i++) begin
      busRd(p, MBX_STAT, v);
      if ((v & mask) == val) break;
    end
  endtask

  task automatic idle(input int p, input int n);
    for (int i = 0; i < n; i++) begin
      if (p == 0) @(negedge p0Clk);
      else        @(negedge p1Clk);
    end
  endtask

  task automatic doReset(input logic sel);
    sideSel = sel;
    p0RstN = 1'b0; p1RstN = 1'b0;
    repeat (4) @(negedge p1Clk);
    p0RstN = 1'b1; p1RstN = 1'b1;
    repeat (2) @(negedge p1Clk);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge p0Clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    p0WrEn = 0; p0RdEn = 0; p0Addr = '0; p0WrData = '0;
    p1WrEn = 0; p1RdEn = 0; p1Addr = '0; p1WrData = '0;
    doReset(1'b0);

    // R1 reset state
    for (int p = 0; p < 2; p++) begin
      busRd(p, MBX_STAT, d); chkEq("R1 status", d, 32'h0000_000F);
      busRd(p, MBX_CTRL, d); chkEq("R1 control", d, 32'h0);
    end
    chkEq("R1 irq", {30'b0, p1Irq, p0Irq}, 32'h0);
    chkEq("R1 peer reset", {30'b0, p1PeerRst, p0PeerRst}, 32'h0);

    // R2 R3 R9: every channel in both directions
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < MBX_CH; c++) begin
        w = (32'h1357_2468 * (c + 1)) ^ (p == 1 ? 32'hFFFF_0000 : 32'h0000_FFFF);
        busWr(p, c, w);
        busRd(p, MBX_STAT, d);
        chkEq("R2 tx empty cleared", {28'b0, d[3:0]}, 32'(4'hF & ~(4'b1 << c)));
        waitStat(1 - p, 32'h1 << (4 + c), 32'h1 << (4 + c), d);
        chkEq("R9 only own rx full bit", {28'b0, d[7:4]}, 32'(4'b1 << c));
        busRd(1 - p, 4 + c, d);
        chkEq("R2 received word", d, w);
        busRd(1 - p, MBX_STAT, d);
        chkEq("R3 rx full cleared by read", {28'b0, d[7:4]}, 32'h0);
        waitStat(p, 32'h1 << c, 32'h1 << c, d);
        chkEq("R3 tx empty restored", {28'b0, d[3:0]}, 32'hF);
      end
    end

    // R4 overwrite of an occupied slot
    busWr(0, 1, 32'hCAFE_0001);
    busWr(0, 1, 32'hDEAD_0002);
    busRd(0, MBX_STAT, d);
    chkEq("R4 error set", {31'b0, d[16]}, 32'h1);
    waitStat(1, 32'h20, 32'h20, d);
    busRd(1, 5, d);
    chkEq("R4 first word kept", d, 32'hCAFE_0001);
    waitStat(0, 32'h2, 32'h2, d);
    chkEq("R4 error still set", {31'b0, d[16]}, 32'h1);
    busWr(0, MBX_STAT, 32'h1 << 16);
    busRd(0, MBX_STAT, d);
    chkEq("R4 error cleared", {31'b0, d[16]}, 32'h0);

    // R5 R6 doorbells in both directions
    for (int p = 0; p < 2; p++) begin
      for (int b = 0; b < MBX_DB; b++) begin
        busWr(p, MBX_RING, 32'h1 << b);
        busRd(p, MBX_STAT, d);
        chkEq("R5 busy set", {28'b0, d[15:12]}, 32'(4'b1 << b));
        waitStat(1 - p, 32'h1 << (8 + b), 32'h1 << (8 + b), d);
        chkEq("R5 pending set", {28'b0, d[11:8]}, 32'(4'b1 << b));
        busWr(p, MBX_RING, 32'h1 << b);
        busWr(1 - p, MBX_STAT, 32'h1 << (8 + b));
        busRd(1 - p, MBX_STAT, d);
        chkEq("R5 pending cleared", {28'b0, d[11:8]}, 32'h0);
        waitStat(p, 32'h1 << (12 + b), 32'h0, d);
        chkEq("R5 busy cleared", {28'b0, d[15:12]}, 32'h0);
        idle(1 - p, 30);
        busRd(1 - p, MBX_STAT, d);
        chkEq("R6 ring while busy ignored", {28'b0, d[11:8]}, 32'h0);
      end
    end

    // R7 interrupt masking
    busWr(1, MBX_CTRL, 32'h1 << 6);
    chkEq("R7 irq low with empty rx", {31'b0, p1Irq}, 32'h0);
    busWr(0, 2, 32'h0BAD_F00D);
    waitStat(1, 32'h40, 32'h40, d);
    chkEq("R7 irq on rx full", {31'b0, p1Irq}, 32'h1);
    busRd(1, 6, d);
    @(negedge p1Clk);
    chkEq("R7 irq drops after read", {31'b0, p1Irq}, 32'h0);
    busWr(1, MBX_CTRL, 32'h0);
    waitStat(0, 32'h4, 32'h4, d);
    busWr(0, MBX_CTRL, 32'h1 << 2);
    chkEq("R7 irq on tx empty", {31'b0, p0Irq}, 32'h1);
    busWr(0, MBX_CTRL, 32'h1 << 8);
    chkEq("R7 irq masked", {31'b0, p0Irq}, 32'h0);
    busWr(1, MBX_RING, 32'h1);
    waitStat(0, 32'h100, 32'h100, d);
    chkEq("R7 irq on doorbell", {31'b0, p0Irq}, 32'h1);
    busWr(0, MBX_STAT, 32'h100);
    chkEq("R7 irq after doorbell clear", {31'b0, p0Irq}, 32'h0);
    busWr(0, MBX_CTRL, 32'h0);

    // R8 reset request under both side selections
    for (int sel = 0; sel < 2; sel++) begin
      doReset(sel[0]);
      busWr(sel, MBX_CTRL, 32'h1 << 12);
      idle(1 - sel, 8);
      chkEq("R8 far peer reset high", {31'b0, (sel == 0) ? p1PeerRst : p0PeerRst}, 32'h1);
      chkEq("R8 A port peer reset low", {31'b0, (sel == 0) ? p0PeerRst : p1PeerRst}, 32'h0);
      busRd(1 - sel, MBX_STAT, d);
      chkEq("R8 status bit 17", {31'b0, d[17]}, 32'h1);
      busWr(1 - sel, MBX_CTRL, 32'h1 << 12);
      busRd(1 - sel, MBX_CTRL, d);
      chkEq("R8 B side request ignored", {31'b0, d[12]}, 32'h0);
      idle(sel, 10);
      chkEq("R8 A port still no peer reset", {31'b0, (sel == 0) ? p0PeerRst : p1PeerRst}, 32'h0);
      busWr(sel, MBX_CTRL, 32'h0);
      idle(1 - sel, 8);
      chkEq("R8 far peer reset released", {31'b0, (sel == 0) ? p1PeerRst : p0PeerRst}, 32'h0);
    end

    finishRun();
  end
endmodule